// File: doc/BRIEF.md
# Register-Based Address Generation Unit

This block forms the effective address of a load or store operand from the contents of a general-purpose register. It also forms the register value to write back. It handles four addressing modes. In register direct, the operand is the register itself and no memory access happens. In register indirect, the register holds the address. In post-increment, the access uses the old register value and the register then advances by the operand size. In pre-decrement, the register first drops by the operand size and the access uses the reduced value.

Each request is one cycle wide: a valid strobe together with the register value, a mode code and an operand-size code. One clock later the block presents a registered result. The result holds the effective address, the write-back value, a write-back enable and a non-memory flag that marks register-direct operands. Address translation, the register file and the memory access itself sit outside this block.

Top module: `agu_core`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, valid_o, wb_en_o and non_mem_o are 0.
- R2: valid_o is 1 in exactly the cycle after a cycle with valid_i high. The result fields in that cycle belong to that request.
- R3: In mode 2'b00 (register direct), ea_o and wb_val_o equal the register value, non_mem_o is 1 and wb_en_o is 0.
- R4: In mode 2'b01 (register indirect), ea_o and wb_val_o equal the register value, and both wb_en_o and non_mem_o are 0.
- R5: In mode 2'b10 (post-increment), ea_o is the unmodified register value, wb_val_o is the register value plus the step, and wb_en_o is 1.
- R6: In mode 2'b11 (pre-decrement), ea_o and wb_val_o both equal the register value minus the step, and wb_en_o is 1.
- R7: The step depends on size_i. It is 1 for 2'b00 (byte), 2 for 2'b01 (word), 4 for 2'b10 (longword) and 8 for 2'b11 (quadword).
- R8: Addition and subtraction wrap modulo 2^32, with no flag. For example, 0xFFFFFFFC plus 8 gives 0x00000004.
- R9: The cycle after valid_i is low, valid_o, wb_en_o and non_mem_o are 0, and ea_o and wb_val_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| reg_val_i | input | 32 | Base register contents |
| mode_i | input | 2 | Addressing mode code |
| size_i | input | 2 | Operand size code |
| valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address (operand value in direct mode) |
| wb_val_o | output | 32 | Register value to write back |
| wb_en_o | output | 1 | Write-back required |
| non_mem_o | output | 1 | Operand is a register, no memory access |

## Verification
Every mode is paired with every size on an aligned base. This separates the step decode from the mode decode, and the direction of post-increment from that of pre-decrement. Base values near zero and near the top of the 32-bit range show whether the arithmetic wraps, and whether pre-decrement applies the step before the access. Back-to-back requests with idle gaps between them check the one-cycle latency, the clearing of the strobes and the holding of the data. A run of pseudo-random requests closes out the comparison against the bench model.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_POSTINC  = 2'b10,
    AM_PREDEC   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } op_size_e;
endpackage

// File: rtl/agu_step.sv
module agu_step
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  op_size_e         size_i,
  output logic [AW-1:0]    step_o
);
  // step = 2^size
  always_comb begin
    step_o = {{(AW-1){1'b0}}, 1'b1} << size_i;
  end

  // R7: exactly one bit set
  always_comb begin
    if (!$isunknown(size_i)) begin
      a_r7_step_onehot: assert ($onehot(step_o));
    end
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] reg_val_i,
  input  addr_mode_e    mode_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_val_o,
  output logic          wb_en_o,
  output logic          non_mem_o
);
  logic [AW-1:0] inc_val, dec_val;

  assign inc_val = reg_val_i + step_i;
  assign dec_val = reg_val_i - step_i;

  always_comb begin
    ea_o      = reg_val_i;
    wb_val_o  = reg_val_i;
    wb_en_o   = 1'b0;
    non_mem_o = 1'b0;
    unique case (mode_i)
      AM_DIRECT:   non_mem_o = 1'b1;
      AM_INDIRECT: ;
      AM_POSTINC: begin
        wb_val_o = inc_val;
        wb_en_o  = 1'b1;
      end
      AM_PREDEC: begin
        ea_o     = dec_val;
        wb_val_o = dec_val;
        wb_en_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  output logic          valid_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_val_o,
  output logic          wb_en_o,
  output logic          non_mem_o
);
  addr_mode_e    mode;
  op_size_e      size;
  logic [AW-1:0] step;
  logic [AW-1:0] ea_d, wb_val_d;
  logic          wb_en_d, non_mem_d;

  assign mode = addr_mode_e'(mode_i);
  assign size = op_size_e'(size_i);

  agu_step #(.AW(AW)) u_step (
    .size_i (size),
    .step_o (step)
  );

  agu_calc #(.AW(AW)) u_calc (
    .reg_val_i (reg_val_i),
    .mode_i    (mode),
    .step_i    (step),
    .ea_o      (ea_d),
    .wb_val_o  (wb_val_d),
    .wb_en_o   (wb_en_d),
    .non_mem_o (non_mem_d)
  );

  // control flags: reset, cleared on idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wb_en_o   <= 1'b0;
      non_mem_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      wb_en_o   <= valid_i & wb_en_d;
      non_mem_o <= valid_i & non_mem_d;
    end
  end

  // data: load on request only, no reset needed
  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      ea_o     <= ea_d;
      wb_val_o <= wb_val_d;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_en_o && !non_mem_o));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && valid_o) |=> ($stable(ea_o) && $stable(wb_val_o)));
  a_r3_direct_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b00) |=> (non_mem_o && !wb_en_o && ea_o == $past(reg_val_i)));
  a_r5_postinc_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10) |=> (wb_en_o && ea_o == $past(reg_val_i)));
  a_r6_predec_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b11) |=> (wb_en_o && ea_o == wb_val_o && ea_o != $past(reg_val_i)));
  a_r1_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_en_o && non_mem_o));
endmodule

// File: tb/agu_core_tb.sv
module agu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] reg_val = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic        valid_o, wb_en_o, non_mem_o;
  logic [31:0] ea_o, wb_val_o;

  int compared = 0;
  int mismatched = 0;

  // model state
  logic [31:0] m_ea = '0, m_wb = '0;

  always #2 clk = ~clk;

  agu_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .reg_val_i(reg_val),
    .mode_i(mode), .size_i(size), .valid_o(valid_o), .ea_o(ea_o),
    .wb_val_o(wb_val_o), .wb_en_o(wb_en_o), .non_mem_o(non_mem_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request (or idle) cycle, compared one cycle later
  task automatic step(input bit v, input logic [1:0] md, input logic [1:0] sz,
                      input logic [31:0] rv, input string tag);
    logic [31:0] st;
    bit e_wb, e_nm;
    string rq;
    @(negedge clk);
    valid = v; mode = md; size = sz; reg_val = rv;
    st = 32'd1 << sz;  // R7
    e_wb = 0; e_nm = 0;
    if (v) begin
      case (md)
        2'b00: begin m_ea = rv; m_wb = rv; e_nm = 1; rq = "R3"; end
        2'b01: begin m_ea = rv; m_wb = rv; rq = "R4"; end
        2'b10: begin m_ea = rv; m_wb = rv + st; e_wb = 1; rq = "R5"; end
        default: begin m_ea = rv - st; m_wb = rv - st; e_wb = 1; rq = "R6"; end
      endcase
    end else rq = "R9";
    if (tag != "") rq = {rq, "/", tag};
    @(posedge clk); #1;
    chk(v ? "R2" : "R9", "valid_o", 32'(valid_o), 32'(v));
    chk(rq, "wb_en_o", 32'(wb_en_o), 32'(e_wb));
    chk(rq, "non_mem_o", 32'(non_mem_o), 32'(e_nm));
    chk(rq, "ea_o", ea_o, m_ea);
    chk(rq, "wb_val_o", wb_val_o, m_wb);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid_o in reset", 32'(valid_o), 0);
    chk("R1", "wb_en_o in reset", 32'(wb_en_o), 0);
    chk("R1", "non_mem_o in reset", 32'(non_mem_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid_o after release", 32'(valid_o), 0);
    chk("R1", "wb_en_o after release", 32'(wb_en_o), 0);

    // R7: every mode with every size
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        step(1, 2'(m), 2'(s), 32'h0000_1000, "R7");

    // R9: idle holds data, gaps between requests
    step(1, 2'b10, 2'b10, 32'h8000_0000, "");
    step(0, 2'b11, 2'b11, 32'h1234_5678, "");
    step(0, 2'b00, 2'b00, 32'h0, "");
    step(1, 2'b00, 2'b01, 32'hCAFE_F00D, "");
    step(0, 2'b10, 2'b11, 32'h0, "");

    // R8: wrap-around at both ends
    for (int s = 0; s < 4; s++) step(1, 2'b10, 2'(s), 32'hFFFF_FFFC, "R8");
    for (int s = 0; s < 4; s++) step(1, 2'b11, 2'(s), 32'h0000_0002, "R8");
    step(1, 2'b11, 2'b11, 32'h0, "R8");

    // pseudo-random run
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[31:29] != 3'd0, lcg[5:4], lcg[9:8], lcg ^ {lcg[15:0], lcg[31:16]}, "");
    end
    step(0, 2'b00, 2'b00, 32'h0, "");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule